// File: doc/BRIEF.md
# Clock Register Map with Coherent Snapshot

This block is the byte-level register file that sits between a serial-bus byte engine and a timekeeping core. The byte engine gives it one strobe per bus event: a start condition, a stop condition, an address byte, a written byte at its acknowledge, or a request for a byte to send. The block keeps a six-bit pointer that walks a 64-byte space. The lowest seven locations are the time and date fields. Location 07h is the control register. Locations 08h to 3Fh are 56 bytes of general storage.

The counting core keeps running while the bus reads the time. For that reason, reads of the time fields are served from a shadow bank. The shadow bank copies the live values only at a start, at a stop, or when the pointer rolls over to zero. A burst read therefore sees one consistent moment in time. A write to a time field is not stored here. Instead, the block sends it to the core as a one-cycle load pulse that carries the field index and the data. Control writes stay in a local register. Storage reads and writes go directly to the array, with no shadow.

Top module: `rtcRegMap`

## Requirements
- R1: After reset, the pointer is 00h, rdByte is 00h, clkLoad is low, all control outputs are low, and every shadow field reads as 00h.
- R2: An address strobe loads the pointer with rxByte[5:0]. Bits 7:6 are ignored. The pointer does not advance on this strobe.
- R3: Each read strobe and each write strobe advances the pointer by one after the access. From 3Fh the pointer goes to 00h.
- R4: The shadow bank copies all seven liveTime bytes at the clock edge that takes a start strobe, a stop strobe, or a pointer advance from 3Fh to 00h. Byte i is liveTime[8i+7:8i].
- R5: A read at pointer i (0 to 6) returns shadow field i ANDed with the mask for that field. The masks for fields 0 to 6 are FF, 7F, 7F, 07, 3F, 1F and FF.
- R6: A write at pointer i (0 to 6) pulses clkLoad for exactly the next cycle. It sets clkLoadIdx to i and clkLoadData to the written byte ANDed with the mask for field i. The shadow bank is not changed by this write.
- R7: A write at 07h stores the byte ANDed with B3h. The control outputs are bit 7 (outLevel), bit 5 (oscStopFlag), bit 4 (sqwEnable) and bits 1:0 (sqwRate). A read at 07h returns the stored value.
- R8: Writes at 08h to 3Fh store the byte in the storage array. Reads in that range return the stored byte directly.
- R9: rdByte takes its new value at the clock edge of a read strobe. It holds that value until the next read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busStart | input | 1 | Start condition seen on the bus |
| busStop | input | 1 | Stop condition seen on the bus |
| addrLoad | input | 1 | rxByte is a register address |
| wrStrobe | input | 1 | rxByte is a data byte at its acknowledge |
| rdStrobe | input | 1 | Byte engine requests the next byte to send |
| rxByte | input | 8 | Received byte |
| liveTime | input | 56 | Live time fields from the counting core, field i in bits 8i+7:8i |
| rdByte | output | 8 | Byte to send for the last read |
| clkLoad | output | 1 | One-cycle load pulse toward the counting core |
| clkLoadIdx | output | 3 | Field index of the load |
| clkLoadData | output | 8 | Masked field value of the load |
| outLevel | output | 1 | Static output level bit |
| oscStopFlag | output | 1 | Oscillator-stop flag bit |
| sqwEnable | output | 1 | Square-wave enable |
| sqwRate | output | 2 | Square-wave rate select |

## Verification
Every result of this block is due exactly one clock edge after the strobe that causes it:

- the read byte;
- the load pulse and its index and data;
- the control outputs;
- the pointer;
- the shadow copy.

The bench raises each strobe at a falling edge and lowers it at the next falling edge. It then samples the outputs at that same falling edge, which lies between the capturing edge and the one after it. It changes liveTime only when it raises a strobe, so the value the shadow bank takes is known. Because the load pulse lasts one cycle, the bench checks on the operation after a clock write that clkLoad has dropped again.

// File: rtl/rtcMapPkg.sv
package rtcMapPkg;

  localparam int DATA_W    = 8;
  localparam int ADDR_W    = 6;
  localparam int TIME_REGS = 7;
  localparam int CTRL_ADDR = 7;
  localparam int FIRST_RAM = 8;
  localparam int MAP_DEPTH = 1 << ADDR_W;
  localparam int RAM_DEPTH = MAP_DEPTH - FIRST_RAM;
  localparam logic [DATA_W-1:0] CTRL_MASK = 8'hB3;

  // Strobes that the control half hands to the datapath half.
  typedef struct packed {
    logic snap;    // copy live time into shadow bank
    logic wrClk;   // write toward a time field
    logic wrCtrl;  // write to the control register
    logic wrRam;   // write to general storage
    logic rdEn;    // capture read data
  } mapStrobe_t;

  // Bits of each time field that are allowed to be nonzero.
  function automatic logic [DATA_W-1:0] fieldMask(input int idx);
    case (idx)
      0:       fieldMask = 8'hFF;
      1:       fieldMask = 8'h7F;
      2:       fieldMask = 8'h7F;
      3:       fieldMask = 8'h07;
      4:       fieldMask = 8'h3F;
      5:       fieldMask = 8'h1F;
      6:       fieldMask = 8'hFF;
      default: fieldMask = CTRL_MASK;
    endcase
  endfunction

endpackage

// File: rtl/rtcMapCtrl.sv
module rtcMapCtrl
  import rtcMapPkg::*;
#(
  parameter int PTR_W    = ADDR_W,
  parameter int N_TIME   = TIME_REGS,
  parameter int CTRL_LOC = CTRL_ADDR
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             busStart,
  input  logic             busStop,
  input  logic             addrLoad,
  input  logic             wrStrobe,
  input  logic             rdStrobe,
  input  logic [PTR_W-1:0] rxAddr,
  output logic [PTR_W-1:0] ptr,
  output mapStrobe_t       strobes
);

  localparam logic [PTR_W-1:0] TIME_END = PTR_W'(N_TIME);
  localparam logic [PTR_W-1:0] CTRL_PTR = PTR_W'(CTRL_LOC);
  localparam logic [PTR_W-1:0] LAST_PTR = '1;

  logic doWrite;
  logic doRead;
  logic step;
  logic wrapNow;
  logic inTime;
  logic inCtrl;

  // Priority: address load, then write, then read.
  always_comb begin
    doWrite = wrStrobe && !addrLoad;
    doRead  = rdStrobe && !addrLoad && !wrStrobe;
    step    = doWrite || doRead;
    wrapNow = step && (ptr == LAST_PTR);
    inTime  = ptr < TIME_END;
    inCtrl  = ptr == CTRL_PTR;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ptr <= '0;
    end else if (addrLoad) begin
      ptr <= rxAddr;
    end else if (step) begin
      ptr <= ptr + 1'b1;
    end
  end

  always_comb begin
    strobes.snap   = busStart || busStop || wrapNow;
    strobes.wrClk  = doWrite && inTime;
    strobes.wrCtrl = doWrite && inCtrl;
    strobes.wrRam  = doWrite && !inTime && !inCtrl;
    strobes.rdEn   = doRead;
  end

endmodule

// File: rtl/rtcMapData.sv
module rtcMapData
  import rtcMapPkg::*;
#(
  parameter int WORD_W   = DATA_W,
  parameter int PTR_W    = ADDR_W,
  parameter int N_TIME   = TIME_REGS,
  parameter int RAM_BASE = FIRST_RAM,
  parameter int N_RAM    = RAM_DEPTH,
  parameter int CTRL_LOC = CTRL_ADDR
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  mapStrobe_t               strobes,
  input  logic [PTR_W-1:0]         ptr,
  input  logic [WORD_W-1:0]        wrData,
  input  logic [N_TIME*WORD_W-1:0] liveTime,
  output logic [WORD_W-1:0]        rdByte,
  output logic                     clkLoad,
  output logic [$clog2(N_TIME)-1:0] clkLoadIdx,
  output logic [WORD_W-1:0]        clkLoadData,
  output logic [WORD_W-1:0]        ctrlReg
);

  localparam int IDX_W  = $clog2(N_TIME);
  localparam int RAM_AW = $clog2(N_RAM);
  localparam logic [PTR_W-1:0] CTRL_PTR = PTR_W'(CTRL_LOC);
  localparam logic [PTR_W-1:0] TIME_END = PTR_W'(N_TIME);

  logic [WORD_W-1:0] shadow [N_TIME];
  logic [WORD_W-1:0] ram    [N_RAM];
  logic [RAM_AW-1:0] ramIdx;
  logic [WORD_W-1:0] timeVal;
  logic [WORD_W-1:0] wrMasked;
  logic [WORD_W-1:0] rdNext;

  // Shadow bank: one register per time field.
  for (genvar g = 0; g < N_TIME; g++) begin : gShadow
    always_ff @(posedge clk) begin
      if (!rstN) begin
        shadow[g] <= '0;
      end else if (strobes.snap) begin
        shadow[g] <= liveTime[g*WORD_W +: WORD_W];
      end
    end
  end

  always_comb begin
    ramIdx = RAM_AW'(ptr - PTR_W'(RAM_BASE));
  end

  // Masked shadow field and masked write data for the current pointer.
  always_comb begin
    timeVal  = '0;
    wrMasked = '0;
    for (int i = 0; i < N_TIME; i++) begin
      if (ptr == PTR_W'(i)) begin
        timeVal  = shadow[i] & fieldMask(i);
        wrMasked = wrData & fieldMask(i);
      end
    end
  end

  always_comb begin
    if (ptr < TIME_END) begin
      rdNext = timeVal;
    end else if (ptr == CTRL_PTR) begin
      rdNext = ctrlReg;
    end else begin
      rdNext = ram[ramIdx];
    end
  end

  always_ff @(posedge clk) begin
    if (strobes.wrRam) begin
      ram[ramIdx] <= wrData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlReg     <= '0;
      rdByte      <= '0;
      clkLoad     <= 1'b0;
      clkLoadIdx  <= '0;
      clkLoadData <= '0;
    end else begin
      if (strobes.wrCtrl) begin
        ctrlReg <= wrData & CTRL_MASK;
      end
      if (strobes.rdEn) begin
        rdByte <= rdNext;
      end
      clkLoad <= strobes.wrClk;
      if (strobes.wrClk) begin
        clkLoadIdx  <= ptr[IDX_W-1:0];
        clkLoadData <= wrMasked;
      end
    end
  end

endmodule

// File: rtl/rtcRegMap.sv
module rtcRegMap
  import rtcMapPkg::*;
(
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        busStart,
  input  logic                        busStop,
  input  logic                        addrLoad,
  input  logic                        wrStrobe,
  input  logic                        rdStrobe,
  input  logic [DATA_W-1:0]           rxByte,
  input  logic [TIME_REGS*DATA_W-1:0] liveTime,
  output logic [DATA_W-1:0]           rdByte,
  output logic                        clkLoad,
  output logic [$clog2(TIME_REGS)-1:0] clkLoadIdx,
  output logic [DATA_W-1:0]           clkLoadData,
  output logic                        outLevel,
  output logic                        oscStopFlag,
  output logic                        sqwEnable,
  output logic [1:0]                  sqwRate
);

  logic [ADDR_W-1:0] ptr;
  mapStrobe_t        strobes;
  logic [DATA_W-1:0] ctrlReg;

  rtcMapCtrl #(
    .PTR_W   (ADDR_W),
    .N_TIME  (TIME_REGS),
    .CTRL_LOC(CTRL_ADDR)
  ) ctrlI (
    .clk     (clk),
    .rstN    (rstN),
    .busStart(busStart),
    .busStop (busStop),
    .addrLoad(addrLoad),
    .wrStrobe(wrStrobe),
    .rdStrobe(rdStrobe),
    .rxAddr  (rxByte[ADDR_W-1:0]),
    .ptr     (ptr),
    .strobes (strobes)
  );

  rtcMapData #(
    .WORD_W  (DATA_W),
    .PTR_W   (ADDR_W),
    .N_TIME  (TIME_REGS),
    .RAM_BASE(FIRST_RAM),
    .N_RAM   (RAM_DEPTH),
    .CTRL_LOC(CTRL_ADDR)
  ) dataI (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .ptr        (ptr),
    .wrData     (rxByte),
    .liveTime   (liveTime),
    .rdByte     (rdByte),
    .clkLoad    (clkLoad),
    .clkLoadIdx (clkLoadIdx),
    .clkLoadData(clkLoadData),
    .ctrlReg    (ctrlReg)
  );

  always_comb begin
    outLevel    = ctrlReg[7];
    oscStopFlag = ctrlReg[5];
    sqwEnable   = ctrlReg[4];
    sqwRate     = ctrlReg[1:0];
  end

endmodule

// File: rtl/rtcRegMapChk.sv
module rtcRegMapChk
  import rtcMapPkg::*;
(
  input logic                         clk,
  input logic                         rstN,
  input logic                         addrLoad,
  input logic                         wrStrobe,
  input logic                         rdStrobe,
  input logic [DATA_W-1:0]            rxByte,
  input logic [ADDR_W-1:0]            ptr,
  input logic [DATA_W-1:0]            rdByte,
  input logic                         clkLoad,
  input logic [$clog2(TIME_REGS)-1:0] clkLoadIdx,
  input logic [DATA_W-1:0]            clkLoadData
);

  logic pastValid;
  always_ff @(posedge clk) begin
    if (!rstN) pastValid <= 1'b0;
    else       pastValid <= 1'b1;
  end

  assert_addr_load_R2: assert property (@(posedge clk) disable iff (!rstN || !pastValid)
    $past(addrLoad) |-> ptr == $past(rxByte[ADDR_W-1:0]));

  assert_ptr_step_R3: assert property (@(posedge clk) disable iff (!rstN || !pastValid)
    $past(!addrLoad && (wrStrobe || rdStrobe)) |-> ptr == $past(ptr) + 1'b1);

  assert_ptr_hold_R3: assert property (@(posedge clk) disable iff (!rstN || !pastValid)
    $past(!addrLoad && !wrStrobe && !rdStrobe) |-> $stable(ptr));

  assert_load_cause_R6: assert property (@(posedge clk) disable iff (!rstN || !pastValid)
    clkLoad |-> $past(wrStrobe && !addrLoad && ptr < ADDR_W'(TIME_REGS)));

  assert_load_mask_R6: assert property (@(posedge clk) disable iff (!rstN || !pastValid)
    clkLoad |-> (clkLoadData & ~fieldMask(int'(clkLoadIdx))) == '0);

  assert_rd_hold_R9: assert property (@(posedge clk) disable iff (!rstN || !pastValid)
    !$past(rdStrobe && !addrLoad && !wrStrobe) |-> $stable(rdByte));

endmodule

bind rtcRegMap rtcRegMapChk chkI (
  .clk        (clk),
  .rstN       (rstN),
  .addrLoad   (addrLoad),
  .wrStrobe   (wrStrobe),
  .rdStrobe   (rdStrobe),
  .rxByte     (rxByte),
  .ptr        (ptr),
  .rdByte     (rdByte),
  .clkLoad    (clkLoad),
  .clkLoadIdx (clkLoadIdx),
  .clkLoadData(clkLoadData)
);

// File: tb/rtcRegMap_tb_top.sv
module rtcRegMap_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busStart = 1'b0;
  logic        busStop = 1'b0;
  logic        addrLoad = 1'b0;
  logic        wrStrobe = 1'b0;
  logic        rdStrobe = 1'b0;
  logic [7:0]  rxByte = '0;
  logic [55:0] liveTime = '0;
  logic [7:0]  rdByte;
  logic        clkLoad;
  logic [2:0]  clkLoadIdx;
  logic [7:0]  clkLoadData;
  logic        outLevel;
  logic        oscStopFlag;
  logic        sqwEnable;
  logic [1:0]  sqwRate;

  always #10 clk = ~clk;

  rtcRegMap dut_i (
    .clk(clk), .rstN(rstN), .busStart(busStart), .busStop(busStop),
    .addrLoad(addrLoad), .wrStrobe(wrStrobe), .rdStrobe(rdStrobe),
    .rxByte(rxByte), .liveTime(liveTime), .rdByte(rdByte),
    .clkLoad(clkLoad), .clkLoadIdx(clkLoadIdx), .clkLoadData(clkLoadData),
    .outLevel(outLevel), .oscStopFlag(oscStopFlag), .sqwEnable(sqwEnable),
    .sqwRate(sqwRate)
  );

  // Reference model state
  int          total = 0;
  int          bad = 0;
  bit          finished = 0;
  logic [5:0]  mPtr = '0;
  logic [7:0]  mShadow [7];
  logic [7:0]  mRam [56];
  logic [7:0]  mCtrl = '0;
  logic [7:0]  mRd = '0;

  localparam int OP_START = 0, OP_STOP = 1, OP_ADDR = 2, OP_WRITE = 3, OP_READ = 4;

  function automatic logic [7:0] expMask(input int i);
    logic [7:0] m [7] = '{8'hFF, 8'h7F, 8'h7F, 8'h07, 8'h3F, 8'h1F, 8'hFF};
    return m[i];
  endfunction

  function automatic logic [7:0] expRead(input logic [5:0] p);
    if (p < 6'd7)       return mShadow[p] & expMask(int'(p));
    else if (p == 6'd7) return mCtrl;
    else                return mRam[p - 6'd8];
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic modelStep(input logic [55:0] liveNow);
    mPtr = mPtr + 1'b1;
    if (mPtr == 6'd0)
      for (int i = 0; i < 7; i++) mShadow[i] = liveNow[i*8 +: 8];
  endtask

  task automatic doOp(input int kind, input logic [7:0] b, input string req);
    logic [55:0] liveNow;
    logic [7:0]  expRd;
    @(negedge clk);
    liveNow  = {$urandom, $urandom} & 56'hFF_FFFF_FFFF_FFFF;
    liveTime = liveNow;
    rxByte   = b;
    case (kind)
      OP_START: busStart = 1'b1;
      OP_STOP:  busStop  = 1'b1;
      OP_ADDR:  addrLoad = 1'b1;
      OP_WRITE: wrStrobe = 1'b1;
      default:  rdStrobe = 1'b1;
    endcase
    @(negedge clk);
    busStart = 1'b0; busStop = 1'b0; addrLoad = 1'b0;
    wrStrobe = 1'b0; rdStrobe = 1'b0;
    case (kind)
      OP_START, OP_STOP: begin
        for (int i = 0; i < 7; i++) mShadow[i] = liveNow[i*8 +: 8];
        check({req, " R4 no load"}, clkLoad, 0);
      end
      OP_ADDR: begin
        mPtr = b[5:0];
        check({req, " R6 no load"}, clkLoad, 0);
      end
      OP_WRITE: begin
        if (mPtr < 6'd7) begin
          check({req, " R6 load"}, clkLoad, 1);
          check({req, " R6 idx"}, clkLoadIdx, mPtr[2:0]);
          check({req, " R6 data"}, clkLoadData, b & expMask(int'(mPtr)));
        end else begin
          check({req, " R6 no load"}, clkLoad, 0);
          if (mPtr == 6'd7) mCtrl = b & 8'hB3;
          else              mRam[mPtr - 6'd8] = b;
        end
        modelStep(liveNow);
      end
      default: begin
        expRd = expRead(mPtr);
        mRd = expRd;
        check({req, (mPtr < 6'd7) ? " R5 time read" : (mPtr == 6'd7) ? " R7 ctrl read" : " R8 ram read"},
              rdByte, expRd);
        check({req, " R6 no load"}, clkLoad, 0);
        modelStep(liveNow);
      end
    endcase
    check({req, " R9 rd hold"}, rdByte, mRd);
    check({req, " R7 ctrl out"}, {outLevel, oscStopFlag, sqwEnable, sqwRate},
          {mCtrl[7], mCtrl[5], mCtrl[4], mCtrl[1:0]});
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : mainSeq
    int seedVal;
    int pick;
    seedVal = $urandom(32'd2718);
    for (int i = 0; i < 7; i++) mShadow[i] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 rdByte", rdByte, 0);
    check("R1 clkLoad", clkLoad, 0);
    check("R1 ctrl", {outLevel, oscStopFlag, sqwEnable, sqwRate}, 0);
    doOp(OP_READ, 8'h00, "R1 shadow reset at ptr 0");

    // R8 fill storage; last write wraps the pointer (R3, R4)
    doOp(OP_ADDR, 8'h08, "R2 load 08");
    for (int i = 0; i < 56; i++) doOp(OP_WRITE, 8'($urandom), "R8 fill");
    for (int i = 0; i < 10; i++) doOp(OP_READ, 8'h00, "R3 R4 after wrap");

    // R2 high address bits ignored, R3 wrap during a read burst
    doOp(OP_ADDR, 8'hFE, "R2 high bits");
    for (int i = 0; i < 4; i++) doOp(OP_READ, 8'h00, "R3 read wrap");

    // R6 all-ones writes to every time field, then shadow untouched
    doOp(OP_START, 8'h00, "R4 start");
    doOp(OP_ADDR, 8'h00, "R2 load 00");
    for (int i = 0; i < 7; i++) doOp(OP_WRITE, 8'hFF, "R6 mask");
    doOp(OP_WRITE, 8'hFF, "R7 ctrl all ones");
    doOp(OP_ADDR, 8'h00, "R2 reload");
    for (int i = 0; i < 8; i++) doOp(OP_READ, 8'h00, "R6 shadow kept");
    doOp(OP_STOP, 8'h00, "R4 stop");
    doOp(OP_ADDR, 8'h07, "R2 ctrl");
    doOp(OP_WRITE, 8'h4C, "R7 ctrl zero bits");

    // Constrained random mix
    for (int n = 0; n < 3000; n++) begin
      pick = int'($urandom % 20);
      if (pick < 1)       doOp(OP_START, 8'h00, "R4 rnd");
      else if (pick < 2)  doOp(OP_STOP, 8'h00, "R4 rnd");
      else if (pick < 4)  doOp(OP_ADDR, 8'($urandom), "R2 rnd");
      else if (pick < 10) doOp(OP_WRITE, 8'($urandom), "R3 rnd");
      else                doOp(OP_READ, 8'h00, "R3 rnd");
    end

    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule